// File: doc/BRIEF.md
# Byte-Wide Static Memory Access Sequencer

This block is a 1 KiB static memory, eight bits wide, with its own access controller. The chip boundary has only two strobes: a read request and a write request. The controller turns each one into the ordered set of internal enables that a static array needs. For a read, these are a timed bit-line precharge, then the sense amplifier, then the output buffer. For a write, every read-path enable is first forced off, and only then is the write driver fired for a single cycle. The storage itself is modelled behaviourally. Word lines and block selects come from two one-hot decoders driven by a latched copy of the byte address.

A read is requested by holding the read strobe high with the address stable. The byte appears on the data output once the buffer turns on, and the valid flag marks it. While the read strobe stays high, moving the address repeats only the precharge. The sense amplifier and buffer stay on, so the next byte arrives without the whole chain running again. A write is requested by holding the write strobe high with address and data. Exactly one drive pulse results. Further pulses happen only when the address moves or the strobe is released and raised again. The internal enables are brought out as plain pins so that the sequence can be observed. There is no valid/ready handshake: the strobes are level requests and the block applies no back-pressure.

Top module: `sram_access_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, pre_en, sense_en, rbuf_en, wdrv_en and rvalid are 0, and rdata is 8'h00.
- R2: Address bits 2:0 pick one of 8 blocks and bits 9:3 pick one of 128 rows. Each of the 1024 addresses holds its own byte, and all 8 bits are written and read together.
- R3: In the first cycle after leaving idle, the decoders drive every output high (the address is invalid). In that cycle no precharge, sense, buffer or write-driver enable is active.
- R4: A read raises pre_en for PRE_CYC cycles. It then leaves all enables low for SENSE_GAP cycles, raises sense_en alone for BUF_GAP cycles, and then raises rbuf_en alongside sense_en. With the defaults of 1, a read strobe first seen at edge k gives pre_en after edge k+1, a gap after k+2, sense_en after k+3 and rbuf_en after k+4.
- R5: rvalid is 1 exactly when the buffer is on in the steady read state and the address input equals the latched address. While rbuf_en is 1, rdata carries the byte stored at the latched address; otherwise rdata is 0.
- R6: If the address changes while a read is steady, rvalid drops in that same cycle. The next cycle has pre_en, sense_en and rbuf_en all 1 with rvalid 0. After PRE_CYC such cycles, rvalid returns with the new byte.
- R7: Before wdrv_en rises, pre_en, sense_en and rbuf_en are all 0 for at least one cycle, and they remain 0 while wdrv_en is 1.
- R8: wdrv_en is 1 for exactly one cycle per access. While wr_en stays high with the same address, no further pulse occurs, and changes to wdata are ignored (the stored byte is unchanged).
- R9: When wr_en is high, write takes priority over rd_en. The cycle after wr_en is seen has pre_en, sense_en and rbuf_en all 0, which aborts any read in progress.
- R10: When both strobes are low, the cycle after has pre_en, sense_en and rbuf_en all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request strobe (level) |
| wr_en | input | 1 | Write request strobe (level, wins over rd_en) |
| addr | input | 10 | Byte address: [2:0] block, [9:3] row |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte read; zero when the output buffer is off |
| rvalid | output | 1 | rdata holds the byte at the current address |
| pre_en | output | 1 | Bit-line precharge enable |
| sense_en | output | 1 | Sense amplifier enable |
| rbuf_en | output | 1 | Read output buffer enable |
| wdrv_en | output | 1 | Write driver enable |

## Verification
The assertions assume that rd_en, wr_en, addr and wdata are synchronous to clk and change only between edges. They also assume reset is held for at least one edge, so the first sampled state is idle. The stimulus changes every input at the falling edge and holds the address steady for a whole read or write unless it is moving the address on purpose, as in the re-address and priority cases. The bench writes a byte before reading it back, because the storage has no reset and the contents of unwritten bytes are never relied on.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_PRE,
    ST_GAP,
    ST_SENSE,
    ST_READ,
    ST_REPRE,
    ST_WQUIET,
    ST_WDRIVE,
    ST_WDONE
  } seq_state_t;
endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode #(
  parameter int BLK_W = 3,
  parameter int ROW_W = 7,
  localparam int NBLK  = 1 << BLK_W,
  localparam int NROWS = 1 << ROW_W
) (
  input  logic                   dec_en,
  input  logic                   dec_wake,
  input  logic [BLK_W+ROW_W-1:0] addr,
  output logic [NBLK-1:0]        blk_oh,
  output logic [NROWS-1:0]       row_oh
);
  always_comb begin
    blk_oh = '0;
    row_oh = '0;
    if (dec_wake) begin
      blk_oh = '1;
      row_oh = '1;
    end else if (dec_en) begin
      blk_oh[addr[BLK_W-1:0]]           = 1'b1;
      row_oh[addr[BLK_W+ROW_W-1:BLK_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int NBLK   = 8,
  parameter int NROWS  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NBLK-1:0]   blk_oh,
  input  logic [NROWS-1:0]  row_oh,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] blk_rd [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [DATA_W-1:0] cells [NROWS];

    always_ff @(posedge clk) begin
      if (we && blk_oh[b]) begin
        for (int r = 0; r < NROWS; r++) begin
          if (row_oh[r]) cells[r] <= wdata;
        end
      end
    end

    always_comb begin
      blk_rd[b] = '0;
      for (int r = 0; r < NROWS; r++) begin
        if (row_oh[r]) blk_rd[b] = blk_rd[b] | cells[r];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (blk_oh[b]) rdata = rdata | blk_rd[b];
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PRE_CYC   = 1,
  parameter int SENSE_GAP = 1,
  parameter int BUF_GAP   = 1,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              pre_en,
  output logic              sense_en,
  output logic              rbuf_en,
  output logic              wdrv_en,
  output logic              read_live,
  output logic              dec_en,
  output logic              dec_wake
);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(SENSE_GAP - 1);
  localparam logic [CNT_W-1:0] SENSE_LAST = CNT_W'(BUF_GAP - 1);

  seq_state_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic ld_addr, ld_wdat, restart;
  logic moved;

  assign moved = (addr != cur_addr);

  always_comb begin
    st_d    = st_q;
    ld_addr = 1'b0;
    ld_wdat = 1'b0;
    restart = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_en || rd_en) begin
          st_d    = ST_WAKE;
          ld_addr = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wr_en) begin
          st_d = ST_WQUIET; ld_addr = 1'b1; ld_wdat = 1'b1;
        end else if (rd_en) begin
          st_d = ST_PRE; ld_addr = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_PRE, ST_GAP, ST_SENSE: begin
        if (wr_en) begin
          st_d = ST_WQUIET; ld_addr = 1'b1; ld_wdat = 1'b1;
        end else if (!rd_en) begin
          st_d = ST_IDLE;
        end else if (moved) begin
          st_d = ST_PRE; ld_addr = 1'b1; restart = 1'b1;
        end else if (st_q == ST_PRE && cnt_q == PRE_LAST) begin
          st_d = ST_GAP;
        end else if (st_q == ST_GAP && cnt_q == GAP_LAST) begin
          st_d = ST_SENSE;
        end else if (st_q == ST_SENSE && cnt_q == SENSE_LAST) begin
          st_d = ST_READ;
        end
      end
      ST_READ: begin
        if (wr_en) begin
          st_d = ST_WQUIET; ld_addr = 1'b1; ld_wdat = 1'b1;
        end else if (!rd_en) begin
          st_d = ST_IDLE;
        end else if (moved) begin
          st_d = ST_REPRE; ld_addr = 1'b1;
        end
      end
      ST_REPRE: begin
        if (wr_en) begin
          st_d = ST_WQUIET; ld_addr = 1'b1; ld_wdat = 1'b1;
        end else if (!rd_en) begin
          st_d = ST_IDLE;
        end else if (moved) begin
          ld_addr = 1'b1; restart = 1'b1;
        end else if (cnt_q == PRE_LAST) begin
          st_d = ST_READ;
        end
      end
      ST_WQUIET: st_d = ST_WDRIVE;
      ST_WDRIVE: st_d = ST_WDONE;
      ST_WDONE: begin
        if (wr_en) begin
          if (moved) begin
            st_d = ST_WQUIET; ld_addr = 1'b1; ld_wdat = 1'b1;
          end
        end else if (rd_en) begin
          st_d = ST_PRE; ld_addr = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q || restart) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
      if (ld_addr) cur_addr  <= addr;
      if (ld_wdat) cur_wdata <= wdata;
    end
  end

  assign pre_en    = (st_q == ST_PRE) || (st_q == ST_REPRE);
  assign sense_en  = (st_q == ST_SENSE) || (st_q == ST_READ) || (st_q == ST_REPRE);
  assign rbuf_en   = (st_q == ST_READ) || (st_q == ST_REPRE);
  assign wdrv_en   = (st_q == ST_WDRIVE);
  assign read_live = (st_q == ST_READ);
  assign dec_en    = (st_q != ST_IDLE);
  assign dec_wake  = (st_q == ST_WAKE);
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq #(
  parameter int BLK_W     = 3,
  parameter int ROW_W     = 7,
  parameter int DATA_W    = 8,
  parameter int PRE_CYC   = 1,
  parameter int SENSE_GAP = 1,
  parameter int BUF_GAP   = 1,
  parameter int CNT_W     = 4,
  localparam int ADDR_W   = BLK_W + ROW_W,
  localparam int NBLK     = 1 << BLK_W,
  localparam int NROWS    = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              pre_en,
  output logic              sense_en,
  output logic              rbuf_en,
  output logic              wdrv_en
);
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] arr_rd;
  logic [NBLK-1:0]   blk_oh;
  logic [NROWS-1:0]  row_oh;
  logic read_live, dec_en, dec_wake;

  sram_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_CYC(PRE_CYC),
    .SENSE_GAP(SENSE_GAP), .BUF_GAP(BUF_GAP), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .pre_en(pre_en), .sense_en(sense_en), .rbuf_en(rbuf_en),
    .wdrv_en(wdrv_en), .read_live(read_live),
    .dec_en(dec_en), .dec_wake(dec_wake)
  );

  sram_addr_decode #(.BLK_W(BLK_W), .ROW_W(ROW_W)) u_dec (
    .dec_en(dec_en), .dec_wake(dec_wake), .addr(cur_addr),
    .blk_oh(blk_oh), .row_oh(row_oh)
  );

  sram_byte_array #(.NBLK(NBLK), .NROWS(NROWS), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(wdrv_en), .blk_oh(blk_oh), .row_oh(row_oh),
    .wdata(cur_wdata), .rdata(arr_rd)
  );

  assign rdata  = rbuf_en ? arr_rd : '0;
  assign rvalid = read_live && (addr == cur_addr);
endmodule

// File: rtl/sram_access_seq_chk.sv
module sram_access_seq_chk #(
  parameter int NBLK  = 8,
  parameter int NROWS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic             pre_en,
  input logic             sense_en,
  input logic             rbuf_en,
  input logic             wdrv_en,
  input logic             rvalid,
  input logic             dec_en,
  input logic             dec_wake,
  input logic [NBLK-1:0]  blk_oh,
  input logic [NROWS-1:0] row_oh
);
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !dec_wake) |-> ($countones(row_oh) == 1 && $countones(blk_oh) == 1)); // R2
  AST_WAKE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dec_wake |-> (&row_oh && &blk_oh && !wdrv_en)); // R3
  AST_BUF_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbuf_en) |-> $past(sense_en)); // R4
  AST_SENSE_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_en) |-> !pre_en); // R4
  AST_VALID_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rbuf_en && sense_en && !pre_en)); // R5
  AST_WDRV_QUIET_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdrv_en) |-> $past(!pre_en && !sense_en && !rbuf_en)); // R7
  AST_WDRV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    wdrv_en |-> !(pre_en || sense_en || rbuf_en)); // R7
  AST_WDRV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdrv_en |=> !wdrv_en); // R8
  AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !(pre_en || sense_en || rbuf_en)); // R9
  AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> !(pre_en || sense_en || rbuf_en)); // R10
endmodule

bind sram_access_seq sram_access_seq_chk #(.NBLK(NBLK), .NROWS(NROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
  .pre_en(pre_en), .sense_en(sense_en), .rbuf_en(rbuf_en),
  .wdrv_en(wdrv_en), .rvalid(rvalid), .dec_en(dec_en),
  .dec_wake(dec_wake), .blk_oh(blk_oh), .row_oh(row_oh)
);

// File: tb/sram_access_seq_test.sv
`timescale 1ns/1ps
module sram_access_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid, pre_en, sense_en, rbuf_en, wdrv_en;
  int total = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  sram_access_seq uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .pre_en(pre_en), .sense_en(sense_en), .rbuf_en(rbuf_en), .wdrv_en(wdrv_en)
  );

  // {is_write, addr[9:0], data[7:0]}; reads expect data
  localparam logic [18:0] VEC [12] = '{
    {1'b1, 10'd0,    8'hA5}, {1'b1, 10'd1023, 8'h5A},
    {1'b1, 10'd7,    8'h11}, {1'b1, 10'd8,    8'h22},
    {1'b1, 10'h155,  8'hC3}, {1'b1, 10'h2AA,  8'h3C},
    {1'b0, 10'd0,    8'hA5}, {1'b0, 10'd1023, 8'h5A},
    {1'b0, 10'd7,    8'h11}, {1'b0, 10'd8,    8'h22},
    {1'b0, 10'h155,  8'hC3}, {1'b0, 10'h2AA,  8'h3C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] ens();
    return {pre_en, sense_en, rbuf_en, wdrv_en};
  endfunction

  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(); chk("R3 wake quiet on write", ens(), 4'b0000);
    step(); chk("R7 quiet before drive", ens(), 4'b0000);
    step(); chk("R7 drive alone", ens(), 4'b0001);
    step(); chk("R8 single drive pulse", ens(), 4'b0000);
    wr_en = 1'b0;
    step(); chk("R10 idle after write", ens(), 4'b0000);
  endtask

  task automatic do_read(input logic [9:0] a, input logic [7:0] d);
    addr = a; rd_en = 1'b1;
    step(); chk("R3 wake quiet on read", ens(), 4'b0000);
    step(); chk("R4 precharge first", ens(), 4'b1000);
    step(); chk("R4 gap before sense", ens(), 4'b0000);
    step(); chk("R4 sense alone", ens(), 4'b0100);
    chk("R5 rdata zero without buffer", rdata, 8'h00);
    step(); chk("R4 sense and buffer", ens(), 4'b0110);
    chk("R5 rvalid with buffer", rvalid, 1'b1);
    chk("R2 byte read back", rdata, d);
    rd_en = 1'b0;
    step(); chk("R10 read path off", ens(), 4'b0000);
    chk("R5 rvalid low after read", rvalid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 enables in reset", ens(), 4'b0000);
    chk("R1 rvalid in reset", rvalid, 1'b0);
    chk("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 enables after reset", ens(), 4'b0000);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][18]) do_write(VEC[i][17:8], VEC[i][7:0]);
      else            do_read(VEC[i][17:8], VEC[i][7:0]);
    end

    // R6: address moves during a steady read
    addr = 10'd7; rd_en = 1'b1;
    repeat (5) step();
    chk("R6 steady before move", rvalid, 1'b1);
    addr = 10'd8;
    #1;
    chk("R6 rvalid drops at once", rvalid, 1'b0);
    step();
    chk("R6 precharge only", ens(), 4'b1110);
    chk("R6 valid low in precharge", rvalid, 1'b0);
    step();
    chk("R6 valid returns", rvalid, 1'b1);
    chk("R6 new byte", rdata, 8'h22);
    chk("R6 read path held", ens(), 4'b0110);

    // R9: write while reading; R8: held strobe, changing data ignored
    addr = 10'd40; wdata = 8'h3C; wr_en = 1'b1;
    step();
    chk("R9 read aborted", ens(), 4'b0000);
    step();
    chk("R9 write driven", ens(), 4'b0001);
    step();
    chk("R8 driver released", ens(), 4'b0000);
    for (int k = 0; k < 3; k++) begin
      wdata = 8'hF0 + 8'(k);
      step();
      chk("R8 no spurious drive", wdrv_en, 1'b0);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    step();
    do_read(10'd40, 8'h3C);

    // R2: neighbours untouched
    do_read(10'd0, 8'hA5);

    ended = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule